// File: doc/BRIEF.md
# Double-Buffered Character Memory Controller

This block holds the character memory of an on-screen display engine in two banks. The CPU reads and writes only the front bank. The display fetch logic reads only the back bank. Edits made by the CPU stay invisible on screen until software asks for the front bank to be copied into the back bank. The copy can start at once, or it can be held back until the next vertical sync so that the picture never changes in the middle of a field.

The same timing choice applies to a display configuration register. A new value written to it reaches the display either on the next clock or at the next vertical sync. The vertical sync is taken from an external input in superimposed mode and from an internally generated sync in text mode. The chosen input passes through a synchronizer, and each of its rising edges sets a sticky interrupt flag.

The CPU port has one space for the memory and one for three registers, chosen by `cpu_reg_sel`. Read data appears on the cycle after the access is accepted.

Top module: `disp_dbuf_ram`

## Requirements
- R1: With `cpu_reg_sel`=0, CPU accesses go to the front bank: writes store `cpu_wdata`, and read data appears on `cpu_rdata` one cycle after acceptance. The display port returns the back-bank word at `disp_addr` one cycle later.
- R2: A front-bank write changes nothing on `disp_rdata` until a copy has carried it into the back bank.
- R3: Writing the control register (register address 0) with bit 0 set starts a copy of every word from the front bank to the back bank. The copy runs in ascending address order, one word per clock, and takes 2^ADDR_W+1 cycles after the accepting edge.
- R4: Control bit 0 reads back as 1 while a copy is pending or running, and as 0 once it has finished.
- R5: While a copy is running, a CPU memory request is held with `cpu_ready` low. It is accepted on the first cycle after the copy ends, so the back bank receives the pre-request contents.
- R6: Control bit 1 selects the timing. When it is 0, the copy starts at once. When it is 1, the copy waits for the first synchronized vsync rising edge after the request.
- R7: A load request made while a copy is pending or running is merged into that copy. Only one copy takes place.
- R8: Control bit 2 selects the vsync source: 1 (superimposed) uses `vs_ext`, 0 (text) uses `vs_int`. The unselected input has no effect.
- R9: Each rising edge of the selected vsync sets the flag in bit 0 of the status register (register address 1). A rising input seen at one edge sets the flag at the third edge, after a two-flop synchronizer. The flag stays set until the CPU writes 1 to it.
- R10: `irq` equals the flag ANDed with control bit 3. Changing bit 3 never alters the flag.
- R11: Only rising edges count. A vsync held high after the flag has been cleared does not set it again.
- R12: A write to the display configuration register (register address 2) reads back at once. It drives `disp_cfg` from the next clock when control bit 1 is 0, or from the next vsync edge when control bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg_sel | input | 1 | 0 = front bank, 1 = register space |
| cpu_addr | input | ADDR_W | Word or register address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request accepted at this edge when high |
| cpu_rdata | output | DATA_W | Read data, valid the cycle after acceptance |
| disp_addr | input | ADDR_W | Display fetch address |
| disp_rdata | output | DATA_W | Back-bank word, one cycle latency |
| disp_cfg | output | DATA_W | Active display configuration |
| vs_ext | input | 1 | External vertical sync |
| vs_int | input | 1 | Internally generated vertical sync |
| irq | output | 1 | Gated vsync interrupt |

## Verification
A copy sequencer stuck in its waiting state shows up in two ways: control bit 0 stays at 1, and the back bank stays stale after a vsync. A skipped or misordered copy address shows up as a wrong word on the display port, found by a full sweep of all addresses right after completion. A wrong copy length changes how many cycles `cpu_ready` stays low, which the bench counts exactly. A wrong synchronizer depth, source selection or edge detector shows up on `irq` within three cycles of the vsync change.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_WAIT,
        CS_COPY,
        CS_DRAIN
    } copy_state_t;

    typedef struct packed {
        logic irq_en;
        logic src_ext;
        logic defer;
    } ctrl_t;

    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_DCFG = 2;

    localparam int CB_LOAD  = 0;
    localparam int CB_DEFER = 1;
    localparam int CB_EXT   = 2;
    localparam int CB_IRQEN = 3;

endpackage

// File: rtl/dbuf_bank.sv
module dbuf_bank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/dbuf_vsync.sv
module dbuf_vsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic src_ext,
    input  logic vs_ext,
    input  logic vs_int,
    output logic vs_pulse
);
    logic                   vs_sel;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    assign vs_sel = src_ext ? vs_ext : vs_int;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= vs_sel;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[SYNC_STAGES-1];
    end

    assign vs_pulse = sync_q[SYNC_STAGES-1] & ~last_q;

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        vs_pulse |=> !vs_pulse);

endmodule

// File: rtl/dbuf_copy_seq.sv
module dbuf_copy_seq
    import dbuf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              defer,
    input  logic              vs_pulse,
    output logic              busy,
    output logic              copy_active,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    copy_state_t       state_q;
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
        end else begin
            wr_en   <= (state_q == CS_COPY);
            wr_addr <= cnt_q;
            unique case (state_q)
                CS_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= defer ? CS_WAIT : CS_COPY;
                end
                CS_WAIT: begin
                    if (vs_pulse) state_q <= CS_COPY;
                end
                CS_COPY: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == TOP) state_q <= CS_DRAIN;
                end
                CS_DRAIN: begin
                    state_q <= CS_IDLE;
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != CS_IDLE);
    assign copy_active = (state_q == CS_COPY) || (state_q == CS_DRAIN);
    assign rd_en       = (state_q == CS_COPY);
    assign rd_addr     = cnt_q;

    // R3: consecutive back-bank writes step through ascending addresses
    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    // R4: pending/running ends only after the top word was written
    a_r4_done_at_top: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(wr_en) && $past(wr_addr) == TOP));

    // R6: a deferred copy does not begin without a vsync edge
    a_r6_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_WAIT && !vs_pulse) |=> (state_q == CS_WAIT));

endmodule

// File: rtl/disp_dbuf_ram.sv
module disp_dbuf_ram
    import dbuf_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_reg_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_rdata,
    output logic [DATA_W-1:0] disp_cfg,
    input  logic              vs_ext,
    input  logic              vs_int,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_DCFG = ADDR_W'(REG_DCFG);

    ctrl_t             ctrl_q;
    logic              irq_flag;
    logic [DATA_W-1:0] cfg_shadow;
    logic              cfg_pend;
    logic              vs_pulse;

    logic              load_busy, copy_active, copy_rd_en, slave_we;
    logic [ADDR_W-1:0] copy_rd_addr, slave_waddr;
    logic [DATA_W-1:0] master_rdata, reg_view, reg_q;
    logic              rd_is_reg;

    logic accept, ram_wr, reg_wr, wr_ctrl, wr_stat, wr_dcfg;
    logic load_start, status_clr, cfg_now;

    assign cpu_ready  = !(cpu_req && !cpu_reg_sel && copy_active);
    assign accept     = cpu_req && cpu_ready;
    assign ram_wr     = accept && !cpu_reg_sel && cpu_we;
    assign reg_wr     = accept && cpu_reg_sel && cpu_we;
    assign wr_ctrl    = reg_wr && (cpu_addr == A_CTRL);
    assign wr_stat    = reg_wr && (cpu_addr == A_STAT);
    assign wr_dcfg    = reg_wr && (cpu_addr == A_DCFG);
    assign load_start = wr_ctrl && cpu_wdata[CB_LOAD];
    assign status_clr = wr_stat && cpu_wdata[0];
    assign cfg_now    = wr_dcfg && !ctrl_q.defer;

    dbuf_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk   (clk),
        .we    (ram_wr),
        .waddr (cpu_addr),
        .wdata (cpu_wdata),
        .raddr (copy_rd_en ? copy_rd_addr : cpu_addr),
        .rdata (master_rdata)
    );

    dbuf_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slave (
        .clk   (clk),
        .we    (slave_we),
        .waddr (slave_waddr),
        .wdata (master_rdata),
        .raddr (disp_addr),
        .rdata (disp_rdata)
    );

    dbuf_copy_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (load_start),
        .defer       (cpu_wdata[CB_DEFER]),
        .vs_pulse    (vs_pulse),
        .busy        (load_busy),
        .copy_active (copy_active),
        .rd_en       (copy_rd_en),
        .rd_addr     (copy_rd_addr),
        .wr_en       (slave_we),
        .wr_addr     (slave_waddr)
    );

    dbuf_vsync #(.SYNC_STAGES(SYNC_STAGES)) u_vsync (
        .clk      (clk),
        .rst      (rst),
        .src_ext  (ctrl_q.src_ext),
        .vs_ext   (vs_ext),
        .vs_int   (vs_int),
        .vs_pulse (vs_pulse)
    );

    // control and interrupt state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.defer   <= cpu_wdata[CB_DEFER];
                ctrl_q.src_ext <= cpu_wdata[CB_EXT];
                ctrl_q.irq_en  <= cpu_wdata[CB_IRQEN];
            end
            if (vs_pulse)        irq_flag <= 1'b1;
            else if (status_clr) irq_flag <= 1'b0;
        end
    end

    // shadowed display configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_shadow <= '0;
            cfg_pend   <= 1'b0;
            disp_cfg   <= '0;
        end else begin
            if (vs_pulse && cfg_pend) begin
                disp_cfg <= cfg_shadow;
                cfg_pend <= 1'b0;
            end
            if (wr_dcfg) begin
                cfg_shadow <= cpu_wdata;
                if (ctrl_q.defer) begin
                    cfg_pend <= 1'b1;
                end else begin
                    disp_cfg <= cpu_wdata;
                    cfg_pend <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        reg_view = '0;
        if (cpu_addr == A_CTRL) begin
            reg_view[CB_LOAD]  = load_busy;
            reg_view[CB_DEFER] = ctrl_q.defer;
            reg_view[CB_EXT]   = ctrl_q.src_ext;
            reg_view[CB_IRQEN] = ctrl_q.irq_en;
        end else if (cpu_addr == A_STAT) begin
            reg_view[0] = irq_flag;
        end else if (cpu_addr == A_DCFG) begin
            reg_view = cfg_shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_is_reg <= 1'b0;
            reg_q     <= '0;
        end else if (accept && !cpu_we) begin
            rd_is_reg <= cpu_reg_sel;
            reg_q     <= reg_view;
        end
    end

    assign cpu_rdata = rd_is_reg ? reg_q : master_rdata;
    assign irq       = irq_flag & ctrl_q.irq_en;

    // R2: the back bank is written only by a copy in progress
    a_r2_slave_only_copy: assert property (@(posedge clk) disable iff (rst)
        slave_we |-> load_busy);

    // R9: every synchronized vsync edge leaves the flag set
    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        vs_pulse |=> irq_flag);

    // R9: the flag drops only after a write-one clear
    a_r9_flag_clear_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag) |-> $past(status_clr));

    // R12: the active configuration moves only on a direct write or a vsync with a pending value
    a_r12_cfg_cause: assert property (@(posedge clk) disable iff (rst)
        (disp_cfg != $past(disp_cfg)) |-> $past(cfg_now || (vs_pulse && cfg_pend)));

    // R5: a running copy never shares the front bank with a CPU write
    a_r5_no_write_in_copy: assert property (@(posedge clk) disable iff (rst)
        copy_rd_en |-> !ram_wr);

endmodule

// File: tb/test_disp_dbuf_ram.sv
`timescale 1ns/1ps
module test_disp_dbuf_ram;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0, cpu_reg_sel = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] disp_addr = '0;
    logic [DW-1:0] disp_rdata, disp_cfg;
    logic          vs_ext = 1'b0, vs_int = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    disp_dbuf_ram #(.ADDR_W(AW), .DATA_W(DW)) i_disp_dbuf_ram (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_reg_sel(cpu_reg_sel),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .disp_addr(disp_addr), .disp_rdata(disp_rdata), .disp_cfg(disp_cfg),
        .vs_ext(vs_ext), .vs_int(vs_int), .irq(irq)
    );

    function automatic logic [DW-1:0] pat(input int seed, input int a);
        return DW'(a * 37 + seed * 11 + 5);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_acc(input bit rs, input bit we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, output logic [DW-1:0] q);
        @(negedge clk);
        cpu_req = 1'b1; cpu_reg_sel = rs; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #0.5;
        while (!cpu_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        q = cpu_rdata;
    endtask

    task automatic reg_wr(input int a, input logic [DW-1:0] d);
        logic [DW-1:0] q;
        cpu_acc(1'b1, 1'b1, AW'(a), d, q);
    endtask

    task automatic reg_rd(input int a, output logic [DW-1:0] q);
        cpu_acc(1'b1, 1'b0, AW'(a), '0, q);
    endtask

    task automatic ram_wr(input int a, input logic [DW-1:0] d);
        logic [DW-1:0] q;
        cpu_acc(1'b0, 1'b1, AW'(a), d, q);
    endtask

    task automatic ram_rd(input int a, output logic [DW-1:0] q);
        cpu_acc(1'b0, 1'b0, AW'(a), '0, q);
    endtask

    task automatic disp_rd(input int a, output logic [DW-1:0] q);
        @(negedge clk);
        disp_addr = AW'(a);
        @(negedge clk);
        q = disp_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit ext);
        @(negedge clk);
        if (ext) vs_ext = 1'b1; else vs_int = 1'b1;
        idle(4);
        if (ext) vs_ext = 1'b0; else vs_int = 1'b0;
        idle(6);
    endtask

    task automatic fill_master(input int seed);
        for (int a = 0; a < N; a++) ram_wr(a, pat(seed, a));
    endtask

    task automatic check_slave(input string req, input int seed);
        logic [DW-1:0] q;
        for (int a = 0; a < N; a++) begin
            disp_rd(a, q);
            check(req, q, pat(seed, a));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] q;
        int lowcnt;

        idle(3);
        rst = 1'b0;
        idle(1);

        // reset state
        check("R10 reset irq", irq, 0);
        check("R12 reset cfg", disp_cfg, 0);
        check("R5 reset ready", cpu_ready, 1);
        reg_rd(0, q);
        check("R4 reset ctrl", q, 0);
        reg_rd(1, q);
        check("R9 reset flag", q, 0);

        // R1: front-bank write/read sweep
        fill_master(0);
        for (int a = 0; a < N; a++) begin
            ram_rd(a, q);
            check("R1 master readback", q, pat(0, a));
        end

        // immediate copy of seed 0 as a known baseline
        reg_wr(0, 8'h01);
        idle(N + 4);
        check_slave("R3 baseline copy", 0);

        // R2: new front-bank data stays off the display
        fill_master(1);
        check_slave("R2 display unaffected", 0);

        // R3/R5: immediate copy, CPU write stalled for the copy duration
        reg_wr(0, 8'h01);
        cpu_req = 1'b1; cpu_reg_sel = 1'b0; cpu_we = 1'b1;
        cpu_addr = AW'(5); cpu_wdata = 8'hEE;
        #0.5;
        lowcnt = 0;
        while (!cpu_ready && lowcnt < 1000) begin
            lowcnt++;
            @(negedge clk);
            #0.5;
        end
        check("R3 R5 stall cycles", lowcnt, N + 1);
        @(negedge clk);
        cpu_req = 1'b0;
        reg_rd(0, q);
        check("R4 load bit clears", q[0], 0);
        check_slave("R3 R5 snapshot", 1);
        ram_rd(5, q);
        check("R5 stalled write landed", q, 8'hEE);

        // R6/R7: deferred copy in text mode, merged second request
        fill_master(2);
        reg_wr(0, 8'h03);
        idle(20);
        reg_rd(0, q);
        check("R4 R6 pending", q[0], 1);
        disp_rd(3, q);
        check("R6 no copy before vsync", q, pat(1, 3));
        reg_wr(0, 8'h03);
        pulse(1'b1);
        idle(N + 4);
        reg_rd(0, q);
        check("R6 R8 ext ignored in text mode", q[0], 1);
        pulse(1'b0);
        idle(N + 4);
        reg_rd(0, q);
        check("R4 R7 done after one vsync", q[0], 0);
        check_slave("R6 deferred copy", 2);
        ram_wr(0, 8'h77);
        pulse(1'b0);
        idle(N + 4);
        disp_rd(0, q);
        check("R7 no queued second copy", q, pat(2, 0));

        // R8/R9: source selection in text mode
        reg_wr(0, 8'h00);
        reg_wr(1, 8'h01);
        reg_rd(1, q);
        check("R9 flag cleared", q[0], 0);
        pulse(1'b1);
        reg_rd(1, q);
        check("R8 text ignores vs_ext", q[0], 0);
        pulse(1'b0);
        reg_rd(1, q);
        check("R8 R9 text uses vs_int", q[0], 1);
        reg_wr(1, 8'h01);

        // R8/R10: superimposed mode, irq disabled
        reg_wr(0, 8'h04);
        pulse(1'b0);
        reg_rd(1, q);
        check("R8 superimposed ignores vs_int", q[0], 0);
        pulse(1'b1);
        reg_rd(1, q);
        check("R8 superimposed uses vs_ext", q[0], 1);
        check("R10 irq gated off", irq, 0);
        reg_wr(0, 8'h0C);
        check("R10 irq enabled", irq, 1);
        reg_rd(1, q);
        check("R10 flag kept by enable", q[0], 1);
        reg_wr(1, 8'h01);
        check("R9 clear drops irq", irq, 0);

        // R9 latency and R11 level insensitivity
        @(negedge clk);
        vs_ext = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 not yet after two edges", irq, 0);
        @(negedge clk);
        check("R9 set at third edge", irq, 1);
        idle(5);
        reg_wr(1, 8'h01);
        idle(10);
        check("R11 held high no reset", irq, 0);
        reg_rd(1, q);
        check("R11 flag stays clear", q[0], 0);
        vs_ext = 1'b0;
        idle(6);

        // R12: configuration register, immediate then deferred
        reg_wr(0, 8'h00);
        reg_wr(2, 8'h5A);
        check("R12 immediate cfg", disp_cfg, 8'h5A);
        reg_wr(0, 8'h02);
        reg_wr(2, 8'hC3);
        idle(10);
        check("R12 deferred holds", disp_cfg, 8'h5A);
        reg_rd(2, q);
        check("R12 readback", q, 8'hC3);
        pulse(1'b0);
        check("R12 applied on vsync", disp_cfg, 8'hC3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule